// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block buffers data words between a producer clocked by one clock and a consumer clocked by another. The two clocks may be unrelated or the very same net. A write is taken on a rising write-clock edge while the write enable is high and the buffer has room. A read is taken on a rising read-clock edge while the read enable is high and data is available. The storage is a simple dual-port array. The read and write pointers cross between the clock domains as gray code through two-flop synchronizers.

A configuration captured at master reset sets two things. The first is the output behaviour: standard, where every word needs a read, or fall-through, where the head word is presented without one. The second is the almost-empty and almost-full thresholds: one of three presets, or two programmed values. A partial reset empties the buffer and leaves that configuration as it was. The two status pins change meaning with the mode. In standard mode they report empty and full. In fall-through mode they report output-ready and input-ready.

Top module: `dcfifo_ft`

## Requirements
- R1: While master reset is held and after it, with no traffic: in standard mode `rd_stat`=1 (empty) and `wr_stat`=0 (not full); in fall-through mode `rd_stat`=0 (no valid output) and `wr_stat`=1 (room available). In both modes `rd_aempty`=1 and `wr_afull`=0.
- R2: In standard mode, a written word stays in the array and `rd_data` does not change until a read takes it. An accepted read at a rising `rd_clk` edge places the oldest word on `rd_data` after that edge, in write order.
- R3: In fall-through mode, the oldest word appears on `rd_data` with `rd_stat`=1 and no read. `rd_data` holds while `rd_en` is low. A read while `rd_stat`=1 consumes that word and loads the next one when one is present.
- R4: A write is accepted only while the buffer has room. In standard mode `wr_stat` becomes 1 after exactly 2^AW words are held. In fall-through mode `wr_stat` becomes 0 after 2^AW+1 words are held (array plus output register). Writes attempted after that are dropped and do not corrupt stored data.
- R5: A read while standard-mode `rd_stat`=1 (empty) or fall-through `rd_stat`=0 is ignored: `rd_data` keeps its value and no word is lost.
- R6: Once traffic has settled, `rd_aempty`=1 exactly when the words held are at or below the almost-empty threshold. Words held means the array count, plus the output register in fall-through mode.
- R7: Once traffic has settled, `wr_afull`=1 exactly when the free array space (2^AW minus the array count) is at or below the almost-full threshold.
- R8: `cfg_sel` is sampled at master reset. 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 64 for both thresholds. 2'b00 takes `ae_prog` and `af_prog`. Changes to `cfg_sel`, `ae_prog`, `af_prog` or `cfg_ft` outside master reset have no effect.
- R9: A partial reset (`prst`=1) empties the buffer and returns the status pins to the R1 values for the current mode. It keeps the mode and thresholds latched at the last master reset.
- R10: Under mixed random traffic, with the two clocks unrelated or identical, every accepted word is read out once, unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous and active high in each domain; latches configuration |
| prst | input | 1 | Partial reset, synchronous and active high in each domain; flush only |
| cfg_ft | input | 1 | 1 selects fall-through mode, 0 standard; sampled at master reset |
| cfg_sel | input | 2 | Threshold preset select; sampled at master reset |
| ae_prog | input | AW+1 | Programmed almost-empty threshold |
| af_prog | input | AW+1 | Programmed almost-full threshold |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through), write clock |
| wr_afull | output | 1 | Almost full, write clock |
| rd_en | input | 1 | Read enable |
| rd_data | output | DW | Read data register |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through), read clock |
| rd_aempty | output | 1 | Almost empty, read clock |

## Verification
Single directed words tell the two modes apart. A lone word that stays hidden until a read shows standard mode, and one that shows up by itself shows fall-through mode. Filling past capacity and then draining shows that dropped writes leave the stored order intact, and repeated reads on an empty buffer show that nothing is lost. Fills that step one word across each threshold (8, 16, 64 and the programmed values) locate the exact flag boundaries. Partial resets after the configuration inputs have been changed show that the latched settings are kept. Seeded random enables on both sides, with the clocks unrelated and then identical, exercise the gray-code crossing against an ordered model.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    THR_PROG = 2'b00,
    THR_8    = 2'b01,
    THR_16   = 2'b10,
    THR_64   = 2'b11
  } thr_sel_e;

  // threshold value picked by the select latched at master reset
  function automatic int unsigned thr_value(thr_sel_e s, int unsigned prog);
    int unsigned v;
    case (s)
      THR_8:   v = 8;
      THR_16:  v = 16;
      THR_64:  v = 64;
      default: v = prog;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dcf_gsync.sv
module dcf_gsync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  // gray to binary: bit i is the xor of all gray bits at or above i
  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^(s2_q >> i);
  end

endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
  import dcf_pkg::*;
#(
  parameter int AW = 7,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          cfg_ft,
  input  thr_sel_e      cfg_sel,
  input  logic [PW-1:0] af_prog,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_ok,
  output logic          stat,
  output logic          afull
);

  logic          rst;
  logic          ft_q;
  logic [PW-1:0] thr_q;
  logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx, free_nx;
  logic          full_q, af_q;

  assign rst = mrst | prst;

  dcf_gsync #(.W(PW)) u_rsync (
    .clk    (clk),
    .rst    (rst),
    .gray_in(rgray),
    .bin_out(rbin_s)
  );

  always_ff @(posedge clk) begin
    if (mrst) begin
      ft_q  <= cfg_ft;
      thr_q <= PW'(thr_value(cfg_sel, 32'(af_prog)));
    end
  end

  assign wr_ok   = wr_en && !full_q;
  assign wbin_nx = wbin + PW'(wr_ok);
  assign cnt_nx  = wbin_nx - rbin_s;
  assign free_nx = PW'(DEPTH) - cnt_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
      af_q   <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      full_q <= (cnt_nx == PW'(DEPTH));
      af_q   <= (free_nx <= thr_q);
    end
  end

  assign waddr = wbin[AW-1:0];
  assign stat  = ft_q ? !full_q : full_q;
  assign afull = af_q;

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= PW'(DEPTH));

  p_full_drops_r4: assert property (@(posedge clk) disable iff (rst)
    full_q && wr_en |=> $stable(wbin));

  p_wgray_step_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
  import dcf_pkg::*;
#(
  parameter int AW = 7,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          cfg_ft,
  input  thr_sel_e      cfg_sel,
  input  logic [PW-1:0] ae_prog,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_load,
  output logic          stat,
  output logic          aempty
);

  logic          rst;
  logic          ft_q;
  logic [PW-1:0] thr_q;
  logic [PW-1:0] rbin, rbin_nx, wbin_s, ram_cnt, held_nx;
  logic          empty_q, ae_q, ov_q, ov_nx;
  logic          consume, fetch, std_ok;

  assign rst = mrst | prst;

  dcf_gsync #(.W(PW)) u_wsync (
    .clk    (clk),
    .rst    (rst),
    .gray_in(wgray),
    .bin_out(wbin_s)
  );

  always_ff @(posedge clk) begin
    if (mrst) begin
      ft_q  <= cfg_ft;
      thr_q <= PW'(thr_value(cfg_sel, 32'(ae_prog)));
    end
  end

  assign ram_cnt = wbin_s - rbin;
  assign std_ok  = rd_en && !empty_q;
  assign consume = rd_en && ov_q;
  assign fetch   = (ram_cnt != '0) && (!ov_q || consume);
  assign rd_load = ft_q ? fetch : std_ok;
  assign rbin_nx = rbin + PW'(rd_load);
  assign ov_nx   = ft_q && (fetch || (ov_q && !consume));
  assign held_nx = (wbin_s - rbin_nx) + PW'(ov_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      ov_q    <= 1'b0;
      empty_q <= 1'b1;
      ae_q    <= 1'b1;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      ov_q    <= ov_nx;
      empty_q <= ((wbin_s - rbin_nx) == '0);
      ae_q    <= (held_nx <= thr_q);
    end
  end

  assign raddr  = rbin[AW-1:0];
  assign stat   = ft_q ? ov_q : empty_q;
  assign aempty = ae_q;

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (wbin_s - rbin) <= PW'(DEPTH));

  p_empty_ignores_r5: assert property (@(posedge clk) disable iff (rst)
    !ft_q && empty_q && rd_en |=> $stable(rbin));

  p_ov_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ft_q && ov_q && !rd_en |=> ov_q && $stable(rbin));

  p_rgray_step_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft
  import dcf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          cfg_ft,
  input  logic [1:0]    cfg_sel,
  input  logic [AW:0]   ae_prog,
  input  logic [AW:0]   af_prog,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stat,
  output logic          wr_afull,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  output logic          rd_aempty
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wgray, rgray;
  logic [AW-1:0] waddr, raddr;
  logic          wr_ok, rd_load;
  logic [DW-1:0] rd_data_q;

  dcf_wside #(.AW(AW)) u_wside (
    .clk    (wr_clk),
    .mrst   (mrst),
    .prst   (prst),
    .cfg_ft (cfg_ft),
    .cfg_sel(thr_sel_e'(cfg_sel)),
    .af_prog(af_prog),
    .wr_en  (wr_en),
    .rgray  (rgray),
    .wgray  (wgray),
    .waddr  (waddr),
    .wr_ok  (wr_ok),
    .stat   (wr_stat),
    .afull  (wr_afull)
  );

  dcf_rside #(.AW(AW)) u_rside (
    .clk    (rd_clk),
    .mrst   (mrst),
    .prst   (prst),
    .cfg_ft (cfg_ft),
    .cfg_sel(thr_sel_e'(cfg_sel)),
    .ae_prog(ae_prog),
    .rd_en  (rd_en),
    .wgray  (wgray),
    .rgray  (rgray),
    .raddr  (raddr),
    .rd_load(rd_load),
    .stat   (rd_stat),
    .aempty (rd_aempty)
  );

  // simple dual-port array, registered read port
  always_ff @(posedge wr_clk) begin
    if (wr_ok) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_load) rd_data_q <= mem[raddr];
  end

  assign rd_data = rd_data_q;

endmodule

// File: tb/test_dcfifo_ft.sv
module test_dcfifo_ft;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
  localparam int DW = 8;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rclk_free = 0, same_clk = 0;
  logic rd_clk;
  logic mrst = 1, prst = 0, cfg_ft = 0;
  logic [1:0] cfg_sel = 2'b01;
  logic [AW:0] ae_prog = '0, af_prog = '0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_stat, wr_afull, rd_stat, rd_aempty;

  int n_tests = 0, n_fail = 0;
  int q[$];
  bit ft_b = 0;
  bit pend = 0;
  int pend_val = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rclk_free = ~rclk_free;
  assign rd_clk = same_clk ? wr_clk : rclk_free;

  dcfifo_ft #(.DW(DW), .AW(AW)) i_dcfifo_ft (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .cfg_ft(cfg_ft), .cfg_sel(cfg_sel), .ae_prog(ae_prog), .af_prog(af_prog),
    .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat), .wr_afull(wr_afull),
    .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat), .rd_aempty(rd_aempty)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit wr_can();
    return ft_b ? wr_stat : !wr_stat;
  endfunction

  task automatic wr_step(bit en, logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = en;
    wr_data = d;
    if (en && wr_can()) q.push_back(int'(d));
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic rd_step(bit en);
    int exp;
    bit acc;
    @(negedge rd_clk);
    if (pend) begin
      chk(int'(rd_data) == pend_val, "R2", "read word", int'(rd_data), pend_val);
      pend = 0;
    end
    if (ft_b && rd_stat) begin
      exp = q.size() > 0 ? q[0] : -1;
      chk(int'(rd_data) == exp, "R3", "presented word", int'(rd_data), exp);
    end
    acc = en && (ft_b ? rd_stat : !rd_stat);
    rd_en = en;
    if (acc) begin
      if (q.size() == 0) chk(0, "R5", "read accepted with no word", 1, 0);
      else begin
        exp = q.pop_front();
        if (!ft_b) begin pend = 1; pend_val = exp; end
      end
    end
  endtask

  task automatic settle();
    #(RD_PERIOD * 10);
  endtask

  task automatic fill_to(int n);
    int g = 0;
    while (q.size() < n && g < 4 * DEPTH) begin
      wr_step(1, DW'($urandom));
      g++;
    end
    wr_idle();
    settle();
  endtask

  task automatic drain();
    int g = 0;
    while (q.size() > 0 && g < 8 * DEPTH) begin
      rd_step(1);
      g++;
    end
    rd_step(0);
    settle();
  endtask

  task automatic do_mrst(bit ft, logic [1:0] sel, int aep, int afp, bit same);
    @(negedge wr_clk);
    mrst = 1; cfg_ft = ft; cfg_sel = sel;
    ae_prog = (AW+1)'(aep); af_prog = (AW+1)'(afp);
    same_clk = same; wr_en = 0; rd_en = 0;
    #(RD_PERIOD * 6);
    @(negedge wr_clk);
    mrst = 0;
    ft_b = ft; q.delete(); pend = 0;
    settle();
  endtask

  task automatic random_run(int n);
    fork
      begin
        for (int i = 0; i < n; i++) wr_step($urandom_range(0, 99) < 60, DW'($urandom));
        wr_idle();
      end
      begin
        for (int i = 0; i < n; i++) rd_step($urandom_range(0, 99) < 55);
        rd_step(0);
      end
    join
    settle();
    drain();
    chk(q.size() == 0, "R10", "words left in model", q.size(), 0);
    chk(rd_stat == ft_b ? 1'b0 : 1'b1, "R10", "drained status", int'(rd_stat), ft_b ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state, standard mode, preset 8
    do_mrst(0, 2'b01, 0, 0, 0);
    chk(rd_stat == 1, "R1", "std empty", int'(rd_stat), 1);
    chk(wr_stat == 0, "R1", "std full", int'(wr_stat), 0);
    chk(rd_aempty == 1, "R1", "aempty", int'(rd_aempty), 1);
    chk(wr_afull == 0, "R1", "afull", int'(wr_afull), 0);

    // R2 standard: word stays in the array until read
    wr_step(1, 8'hA5); wr_idle(); settle();
    chk(rd_stat == 0, "R2", "not empty after write", int'(rd_stat), 0);
    rd_step(1); rd_step(0);
    wr_step(1, 8'h3C); wr_idle(); settle();
    chk(rd_data == 8'hA5, "R2", "data unchanged without read", int'(rd_data), 'hA5);
    rd_step(1); rd_step(0); settle();

    // R5 reads on empty are ignored
    for (int i = 0; i < 5; i++) rd_step(1);
    rd_step(0);
    chk(rd_data == 8'h3C, "R5", "data after empty reads", int'(rd_data), 'h3C);
    chk(rd_stat == 1, "R5", "still empty", int'(rd_stat), 1);
    wr_step(1, 8'h77); wr_idle(); settle();
    rd_step(1); rd_step(0); settle();

    // R6 / R7 boundaries at threshold 8, then R4 full
    fill_to(8);
    chk(rd_aempty == 1, "R6", "8 held thr 8", int'(rd_aempty), 1);
    fill_to(9);
    chk(rd_aempty == 0, "R6", "9 held thr 8", int'(rd_aempty), 0);
    fill_to(DEPTH - 9);
    chk(wr_afull == 0, "R7", "free 9 thr 8", int'(wr_afull), 0);
    fill_to(DEPTH - 8);
    chk(wr_afull == 1, "R7", "free 8 thr 8", int'(wr_afull), 1);
    for (int i = 0; i < 12; i++) wr_step(1, DW'($urandom));
    wr_idle(); settle();
    chk(wr_stat == 1, "R4", "full flag", int'(wr_stat), 1);
    chk(q.size() == DEPTH, "R4", "words accepted", q.size(), DEPTH);
    drain();
    chk(rd_stat == 1, "R4", "empty after drain", int'(rd_stat), 1);

    // R8 preset 16
    do_mrst(0, 2'b10, 0, 0, 0);
    fill_to(16);
    chk(rd_aempty == 1, "R8", "16 held thr 16", int'(rd_aempty), 1);
    fill_to(17);
    chk(rd_aempty == 0, "R8", "17 held thr 16", int'(rd_aempty), 0);
    fill_to(DEPTH - 17);
    chk(wr_afull == 0, "R8", "free 17 thr 16", int'(wr_afull), 0);
    fill_to(DEPTH - 16);
    chk(wr_afull == 1, "R8", "free 16 thr 16", int'(wr_afull), 1);

    // R8 preset 64
    do_mrst(0, 2'b11, 0, 0, 0);
    fill_to(63);
    chk(wr_afull == 0, "R8", "free 65 thr 64", int'(wr_afull), 0);
    fill_to(64);
    chk(wr_afull == 1, "R8", "free 64 thr 64", int'(wr_afull), 1);
    chk(rd_aempty == 1, "R8", "64 held thr 64", int'(rd_aempty), 1);
    fill_to(65);
    chk(rd_aempty == 0, "R8", "65 held thr 64", int'(rd_aempty), 0);

    // R8 programmed thresholds, inputs changed after reset
    do_mrst(0, 2'b00, 3, 5, 0);
    cfg_sel = 2'b11; ae_prog = 50; af_prog = 60; cfg_ft = 1;
    fill_to(3);
    chk(rd_aempty == 1, "R8", "3 held prog 3", int'(rd_aempty), 1);
    fill_to(4);
    chk(rd_aempty == 0, "R8", "4 held prog 3", int'(rd_aempty), 0);
    fill_to(DEPTH - 6);
    chk(wr_afull == 0, "R8", "free 6 prog 5", int'(wr_afull), 0);
    fill_to(DEPTH - 5);
    chk(wr_afull == 1, "R8", "free 5 prog 5", int'(wr_afull), 1);

    // R1 / R3 fall-through mode
    do_mrst(1, 2'b10, 0, 0, 0);
    chk(rd_stat == 0, "R1", "ft output not ready", int'(rd_stat), 0);
    chk(wr_stat == 1, "R1", "ft input ready", int'(wr_stat), 1);
    wr_step(1, 8'h5A); wr_idle(); settle();
    chk(rd_stat == 1, "R3", "ready without read", int'(rd_stat), 1);
    chk(rd_data == 8'h5A, "R3", "first word shown", int'(rd_data), 'h5A);
    wr_step(1, 8'hC3); wr_idle(); settle();
    chk(rd_data == 8'h5A, "R3", "held without read", int'(rd_data), 'h5A);
    rd_step(1); rd_step(0); settle();
    chk(rd_data == 8'hC3, "R3", "next word loaded", int'(rd_data), 'hC3);
    rd_step(1); rd_step(0); settle();
    chk(rd_stat == 0, "R5", "ft not ready when drained", int'(rd_stat), 0);

    // R4 fall-through capacity
    for (int i = 0; i < DEPTH + 6; i++) wr_step(1, DW'($urandom));
    wr_idle(); settle();
    chk(wr_stat == 0, "R4", "ft input not ready", int'(wr_stat), 0);
    chk(q.size() == DEPTH + 1, "R4", "ft words held", q.size(), DEPTH + 1);
    drain();

    // R6 fall-through counts the output register
    fill_to(16);
    chk(rd_aempty == 1, "R6", "ft 16 held", int'(rd_aempty), 1);
    fill_to(17);
    chk(rd_aempty == 0, "R6", "ft 17 held", int'(rd_aempty), 0);

    // R9 partial reset keeps mode and thresholds
    cfg_ft = 0; cfg_sel = 2'b01;
    @(negedge wr_clk); prst = 1;
    #(RD_PERIOD * 6);
    @(negedge wr_clk); prst = 0;
    q.delete(); pend = 0;
    settle();
    chk(rd_stat == 0, "R9", "ft output not ready", int'(rd_stat), 0);
    chk(wr_stat == 1, "R9", "ft input ready", int'(wr_stat), 1);
    chk(rd_aempty == 1, "R9", "aempty after flush", int'(rd_aempty), 1);
    fill_to(16);
    chk(rd_aempty == 1, "R9", "thr 16 kept at 16", int'(rd_aempty), 1);
    fill_to(17);
    chk(rd_aempty == 0, "R9", "thr 16 kept at 17", int'(rd_aempty), 0);
    chk(rd_stat == 1, "R9", "fall-through kept", int'(rd_stat), 1);
    drain();

    // R10 random traffic
    do_mrst(0, 2'b01, 0, 0, 0);
    random_run(3000);
    do_mrst(1, 2'b10, 0, 0, 0);
    random_run(3000);
    do_mrst(1, 2'b11, 0, 0, 1);
    random_run(3000);
    do_mrst(0, 2'b10, 0, 0, 1);
    random_run(2000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule